// File: doc/BRIEF.md
# Page Table Entry Validity Checker

This block takes one page table entry, presented as a 64-bit word during address translation, and decides whether a page walker may use it. It sorts the entry into one of three classes: an entry that must be rejected, a pointer to the next table level, or a leaf mapping. Alongside the class it reports a small code that says why an entry was rejected. The walker supplies the entry together with two qualifiers. One selects 32-bit or 64-bit entry layout. The other enables the stricter reserved-bit rules that newer privileged architecture revisions require.

Entries enter through a valid/ready handshake and the verdict comes back one cycle later. The verdict is held until the consumer takes it, so the block sits directly in a walker's pipeline and can apply back-pressure. A parameter can remove 64-bit support entirely. In that case the upper extension field never takes part in the decision.

Top module: `pte_validity_checker`

## Requirements
- R1: Flag bits sit in the low byte of the entry, with bit 0 = V, 1 = R, 2 = W, 3 = X, 4 = U, 5 = G, 6 = A and 7 = D. An entry with V = 0 is rejected with cause code 1.
- R2: An entry with W = 1 and R = 0 is rejected with cause code 2.
- R3: An accepted entry with X, W and R all 0 is reported as a pointer (is_pointer = 1, is_leaf = 0). Any other accepted entry is reported as a leaf (is_leaf = 1, is_pointer = 0). In both cases the cause is 0 and invalid is 0.
- R4: With strict mode on, a pointer-shaped entry with any of A, D or U set is rejected with cause code 3. Leaf entries with those bits set are not affected.
- R5: With strict mode on and 64-bit layout selected, any set bit in entry bits 63..54 rejects the entry with cause code 4. Bits 53..8 never affect the verdict.
- R6: With 32-bit layout selected, entry bits 63..54 are treated as zero and never cause rejection.
- R7: With strict mode off, only the R1 and R2 rules can reject an entry. Set A/D/U bits on a pointer and a non-zero extension field are both ignored.
- R8: When several rejection rules apply, the lowest non-zero cause code is reported.
- R9: A rejected entry drives invalid = 1 with is_leaf = 0 and is_pointer = 0. invalid is 1 exactly when the cause is non-zero.
- R10: An entry is taken on a clock edge where in_valid and in_ready are both high. Its verdict appears after that edge with out_valid = 1 and stays unchanged while out_ready is low. in_ready is high when out_valid is low or out_ready is high.
- R11: A synchronous active-high reset clears out_valid, invalid, is_leaf, is_pointer and the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An entry is offered |
| in_ready | output | 1 | The block can take an entry this cycle |
| in_pte | input | 64 | Page table entry word |
| in_mode64 | input | 1 | 1 = 64-bit entry layout, 0 = 32-bit |
| in_strict | input | 1 | 1 = apply reserved-bit rules |
| out_valid | output | 1 | A verdict is presented |
| out_ready | input | 1 | The consumer takes the verdict |
| out_invalid | output | 1 | The entry must be rejected |
| out_is_leaf | output | 1 | The entry is a usable leaf |
| out_is_pointer | output | 1 | The entry points to the next level |
| out_cause | output | 3 | Rejection reason: 0 none, 1 V clear, 2 W without R, 3 reserved A/D/U on pointer, 4 extension field set |

## Verification
Every verdict is due exactly one cycle after the edge that takes its entry, because a single register stage sits between in_pte and the result outputs. The bench drives each entry on a falling edge, lets one rising edge pass, and reads the result on the next falling edge. While out_ready is low the verdict has to stay fixed for as many cycles as the stall lasts. The stall test samples it on several successive falling edges and then checks that the waiting entry shows up one edge after out_ready rises. in_ready is combinational, so it is checked on the same falling edge at which out_ready changes.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

   localparam int FLAG_W   = 8;
   localparam int CAUSE_W  = 3;

   localparam int FB_V = 0;
   localparam int FB_R = 1;
   localparam int FB_W = 2;
   localparam int FB_X = 3;
   localparam int FB_U = 4;
   localparam int FB_G = 5;
   localparam int FB_A = 6;
   localparam int FB_D = 7;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE     = 3'd0,
      CAUSE_V_CLEAR  = 3'd1,
      CAUSE_W_NO_R   = 3'd2,
      CAUSE_PTR_RSVD = 3'd3,
      CAUSE_EXT_SET  = 3'd4
   } cause_e;

   typedef struct packed {
      logic   invalid;
      logic   is_leaf;
      logic   is_ptr;
      cause_e cause;
   } verdict_t;

   localparam verdict_t VERDICT_CLEAR = '{invalid: 1'b0, is_leaf: 1'b0,
                                          is_ptr: 1'b0, cause: CAUSE_NONE};

endpackage

// File: rtl/pte_flag_decode.sv
module pte_flag_decode
   import pte_chk_pkg::*;
(
   input  logic [FLAG_W-1:0] flags,
   output logic              v_clear,
   output logic              w_no_r,
   output logic              ptr_shape,
   output logic              ptr_rsvd
);
   logic [2:0] perm_bits;
   logic [2:0] ptr_only_zero;

   assign perm_bits     = {flags[FB_X], flags[FB_W], flags[FB_R]};
   assign ptr_only_zero = {flags[FB_A], flags[FB_D], flags[FB_U]};

   always_comb begin
      v_clear   = ~flags[FB_V];
      w_no_r    = flags[FB_W] & ~flags[FB_R];
      ptr_shape = (perm_bits == 3'b000);
      ptr_rsvd  = ptr_shape & (|ptr_only_zero);
   end

   // The global bit plays no part in the validity decision.
   logic unused_g;
   assign unused_g = flags[FB_G];
endmodule

// File: rtl/pte_ext_field.sv
module pte_ext_field #(
   parameter int EXT_W  = 10,
   parameter bit HAS_64 = 1'b1
) (
   input  logic [EXT_W-1:0] ext_raw,
   input  logic             mode64,
   output logic [EXT_W-1:0] ext_eff,
   output logic             ext_nz
);
   generate
      if (HAS_64) begin : g_wide
         assign ext_eff = mode64 ? ext_raw : '0;
      end else begin : g_narrow
         logic unused_raw;
         assign unused_raw = (|ext_raw) | mode64;
         assign ext_eff    = '0;
      end
   endgenerate

   assign ext_nz = |ext_eff;
endmodule

// File: rtl/pte_verdict_sel.sv
module pte_verdict_sel
   import pte_chk_pkg::*;
(
   input  logic     strict,
   input  logic     v_clear,
   input  logic     w_no_r,
   input  logic     ptr_shape,
   input  logic     ptr_rsvd,
   input  logic     ext_nz,
   output verdict_t verdict
);
   logic rule_rsvd;
   logic rule_ext;

   assign rule_rsvd = strict & ptr_rsvd;
   assign rule_ext  = strict & ext_nz;

   always_comb begin
      verdict = VERDICT_CLEAR;
      if (v_clear)        verdict.cause = CAUSE_V_CLEAR;
      else if (w_no_r)    verdict.cause = CAUSE_W_NO_R;
      else if (rule_rsvd) verdict.cause = CAUSE_PTR_RSVD;
      else if (rule_ext)  verdict.cause = CAUSE_EXT_SET;
      else                verdict.cause = CAUSE_NONE;

      verdict.invalid = (verdict.cause != CAUSE_NONE);
      verdict.is_ptr  = ~verdict.invalid & ptr_shape;
      verdict.is_leaf = ~verdict.invalid & ~ptr_shape;
   end
endmodule

// File: rtl/pte_verdict_reg.sv
module pte_verdict_reg
   import pte_chk_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     in_valid,
   output logic     in_ready,
   input  verdict_t next_verdict,
   output logic     out_valid,
   input  logic     out_ready,
   output verdict_t held_verdict
);
   logic take;

   assign in_ready = ~out_valid | out_ready;
   assign take     = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         held_verdict <= VERDICT_CLEAR;
      end else if (take) begin
         out_valid    <= 1'b1;
         held_verdict <= next_verdict;
      end else if (out_ready) begin
         out_valid    <= 1'b0;
      end
   end
endmodule

// File: rtl/pte_validity_checker.sv
module pte_validity_checker
   import pte_chk_pkg::*;
#(
   parameter int PTE_W   = 64,
   parameter int EXT_LSB = 54,
   parameter int EXT_W   = 10,
   parameter bit HAS_64  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [PTE_W-1:0]   in_pte,
   input  logic               in_mode64,
   input  logic               in_strict,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_invalid,
   output logic               out_is_leaf,
   output logic               out_is_pointer,
   output logic [CAUSE_W-1:0] out_cause
);
   localparam int EXT_MSB = EXT_LSB + EXT_W - 1;

   initial begin
      if (EXT_MSB >= PTE_W)
         $fatal(1, "extension field exceeds entry width");
      if (EXT_LSB < FLAG_W)
         $fatal(1, "extension field overlaps flag byte");
   end

   logic [FLAG_W-1:0] flags;
   logic [EXT_W-1:0]  ext_eff;
   logic              v_clear, w_no_r, ptr_shape, ptr_rsvd, ext_nz;
   verdict_t          next_verdict, held_verdict;

   assign flags = in_pte[FLAG_W-1:0];

   pte_flag_decode u_flags (
      .flags     (flags),
      .v_clear   (v_clear),
      .w_no_r    (w_no_r),
      .ptr_shape (ptr_shape),
      .ptr_rsvd  (ptr_rsvd)
   );

   pte_ext_field #(.EXT_W(EXT_W), .HAS_64(HAS_64)) u_ext (
      .ext_raw (in_pte[EXT_MSB:EXT_LSB]),
      .mode64  (in_mode64),
      .ext_eff (ext_eff),
      .ext_nz  (ext_nz)
   );

   pte_verdict_sel u_sel (
      .strict    (in_strict),
      .v_clear   (v_clear),
      .w_no_r    (w_no_r),
      .ptr_shape (ptr_shape),
      .ptr_rsvd  (ptr_rsvd),
      .ext_nz    (ext_nz),
      .verdict   (next_verdict)
   );

   pte_verdict_reg u_reg (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .next_verdict (next_verdict),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .held_verdict (held_verdict)
   );

   assign out_invalid    = held_verdict.invalid;
   assign out_is_leaf    = held_verdict.is_leaf;
   assign out_is_pointer = held_verdict.is_ptr;
   assign out_cause      = held_verdict.cause;
endmodule

// File: rtl/pte_validity_checker_chk.sv
module pte_validity_checker_chk (
   input logic       clk,
   input logic       rst,
   input logic       in_valid,
   input logic       in_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic       out_invalid,
   input logic       out_is_leaf,
   input logic       out_is_pointer,
   input logic [2:0] out_cause
);
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid &&
      $stable({out_invalid, out_is_leaf, out_is_pointer, out_cause}));

   a_r10_accept: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);

   a_r10_stall: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);

   a_r9_reject_class: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_invalid |-> !out_is_leaf && !out_is_pointer);

   a_r9_cause_match: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_invalid == (out_cause != 3'd0)));

   a_r3_one_class: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_invalid |-> $onehot0({out_is_leaf, out_is_pointer}) &&
      (out_is_leaf || out_is_pointer));

   a_r8_cause_range: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_cause <= 3'd4);

   a_r11_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid && !out_invalid && out_cause == 3'd0);
endmodule

bind pte_validity_checker pte_validity_checker_chk u_chk (
   .clk            (clk),
   .rst            (rst),
   .in_valid       (in_valid),
   .in_ready       (in_ready),
   .out_valid      (out_valid),
   .out_ready      (out_ready),
   .out_invalid    (out_invalid),
   .out_is_leaf    (out_is_leaf),
   .out_is_pointer (out_is_pointer),
   .out_cause      (out_cause)
);

// File: tb/pte_validity_checker_test.sv
`timescale 1ns/1ps
module pte_validity_checker_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_pte = '0;
   logic        in_mode64 = 1'b1;
   logic        in_strict = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic        out_invalid, out_is_leaf, out_is_pointer;
   logic [2:0]  out_cause;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   pte_validity_checker uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_pte(in_pte), .in_mode64(in_mode64), .in_strict(in_strict),
      .out_valid(out_valid), .out_ready(out_ready), .out_invalid(out_invalid),
      .out_is_leaf(out_is_leaf), .out_is_pointer(out_is_pointer),
      .out_cause(out_cause)
   );

   // Expected cause from the rules: V clear 1, W-without-R 2,
   // strict pointer with A/D/U 3, strict 64-bit extension set 4.
   function automatic logic [2:0] model_cause(input logic [63:0] p,
                                              input logic m64, input logic s);
      logic ptr;
      ptr = (p[3:1] == 3'b000);
      if (!p[0])                             return 3'd1;
      if (p[2] && !p[1])                     return 3'd2;
      if (s && ptr && (p[6] | p[7] | p[4]))  return 3'd3;
      if (s && m64 && (|p[63:54]))           return 3'd4;
      return 3'd0;
   endfunction

   task automatic check(input string req, input logic [5:0] act,
                        input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual{v,inv,leaf,ptr,cause}=%b expected=%b",
                  req, act, exp);
      end
   endtask

   function automatic logic [5:0] observed();
      return {out_valid, out_invalid, out_is_leaf, out_is_pointer, out_cause[1:0]}
             ^ {5'b0, 1'b0};
   endfunction

   task automatic send_check(input string req, input logic [63:0] p,
                             input logic m64, input logic s);
      logic [2:0] c;
      logic       ptr;
      c   = model_cause(p, m64, s);
      ptr = (p[3:1] == 3'b000);
      @(negedge clk);
      in_pte = p; in_mode64 = m64; in_strict = s;
      in_valid = 1'b1; out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (!(out_valid === 1'b1 && out_invalid === (c != 0) &&
            out_is_leaf === (c == 0 && !ptr) && out_is_pointer === (c == 0 && ptr) &&
            out_cause === c)) begin
         failures++;
         $display("FAIL %s pte=%h actual v=%b inv=%b leaf=%b ptr=%b cause=%0d expected inv=%b leaf=%b ptr=%b cause=%0d",
                  req, p, out_valid, out_invalid, out_is_leaf, out_is_pointer, out_cause,
                  c != 0, c == 0 && !ptr, c == 0 && ptr, c);
      end
   endtask

   task automatic expect_cause(input string req, input logic [63:0] p,
                               input logic m64, input logic s, input logic [2:0] c);
      checks++;
      if (model_cause(p, m64, s) !== c) begin
         failures++;
         $display("FAIL %s bench model actual=%0d expected=%0d", req,
                  model_cause(p, m64, s), c);
      end
      send_check(req, p, m64, s);
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R11 reset state", {out_valid, out_invalid, out_is_leaf, out_is_pointer,
                               out_cause[1:0]}, 6'b0);
      check("R11 reset cause msb", {5'b0, out_cause[2]}, 6'b0);
      check("R10 ready when idle", {5'b0, in_ready}, 6'b1);
      rst = 1'b0;
   endtask

   task automatic t_flag_sweep();
      for (int s = 0; s < 2; s++)
         for (int f = 0; f < 256; f++)
            send_check(s ? "R1 R2 R3 R4 R9 sweep strict" : "R7 R1 R2 R3 sweep lax",
                       64'h0000_1234_5678_9A00 | 64'(f), 1'b1, s[0]);
   endtask

   task automatic t_fixed_cases();
      expect_cause("R1 V clear",         64'h0000_0000_0000_000E, 1'b1, 1'b1, 3'd1);
      expect_cause("R2 W without R",     64'h0000_0000_0000_0005, 1'b1, 1'b1, 3'd2);
      expect_cause("R3 pointer",         64'h0000_0000_0000_0001, 1'b1, 1'b1, 3'd0);
      expect_cause("R3 leaf",            64'h0000_0000_0000_000B, 1'b1, 1'b1, 3'd0);
      expect_cause("R4 pointer with D",  64'h0000_0000_0000_0081, 1'b1, 1'b1, 3'd3);
      expect_cause("R4 leaf with ADU ok",64'h0000_0000_0000_00D3, 1'b1, 1'b1, 3'd0);
      expect_cause("R7 lax pointer ADU", 64'h0000_0000_0000_00D1, 1'b1, 1'b0, 3'd0);
   endtask

   task automatic t_ext_field();
      for (int b = 54; b < 64; b++)
         expect_cause("R5 ext bit set", (64'd1 << b) | 64'h3, 1'b1, 1'b1, 3'd4);
      expect_cause("R5 bit 53 ignored", (64'd1 << 53) | 64'h3, 1'b1, 1'b1, 3'd0);
      expect_cause("R5 mid bits ignored", 64'h003F_FFFF_FFFF_FF03, 1'b1, 1'b1, 3'd0);
      expect_cause("R7 lax ext ignored", 64'hFFC0_0000_0000_0003, 1'b1, 1'b0, 3'd0);
   endtask

   task automatic t_mode32();
      expect_cause("R6 32-bit ext ignored", 64'hFFC0_0000_0000_0003, 1'b0, 1'b1, 3'd0);
      expect_cause("R6 32-bit pointer",     64'hFFC0_0000_0000_0001, 1'b0, 1'b1, 3'd0);
      expect_cause("R6 32-bit rsvd still",  64'hFFC0_0000_0000_0011, 1'b0, 1'b1, 3'd3);
   endtask

   task automatic t_priority();
      expect_cause("R8 V beats all",     64'hFFC0_0000_0000_00F4, 1'b1, 1'b1, 3'd1);
      expect_cause("R8 WnoR beats ext",  64'hFFC0_0000_0000_0005, 1'b1, 1'b1, 3'd2);
      expect_cause("R8 rsvd beats ext",  64'hFFC0_0000_0000_0041, 1'b1, 1'b1, 3'd3);
   endtask

   task automatic t_handshake();
      @(negedge clk);
      out_ready = 1'b0;
      in_pte = 64'h0000_0000_0000_0000; in_mode64 = 1'b1; in_strict = 1'b1;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R10 first verdict", {out_valid, out_invalid, out_is_leaf, out_is_pointer,
                                  out_cause[1:0]}, 6'b110001);
      check("R10 stalled not ready", {5'b0, in_ready}, 6'b0);
      in_pte = 64'h0000_0000_0000_000F;
      repeat (3) begin
         @(posedge clk);
         @(negedge clk);
         check("R10 held while stalled", {out_valid, out_invalid, out_is_leaf,
                                         out_is_pointer, out_cause[1:0]}, 6'b110001);
         check("R10 still not ready", {5'b0, in_ready}, 6'b0);
      end
      out_ready = 1'b1;
      #0.5;
      check("R10 ready follows out_ready", {5'b0, in_ready}, 6'b1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 waiting entry taken", {out_valid, out_invalid, out_is_leaf,
                                        out_is_pointer, out_cause[1:0]}, 6'b101000);
      @(posedge clk);
      @(negedge clk);
      check("R10 drained", {5'b0, out_valid}, 6'b0);
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      out_ready = 1'b0;
      in_pte = 64'h0000_0000_0000_0004; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 pre-reset verdict", {out_valid, out_invalid, 4'b0}, 6'b110000);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R11 cleared by reset", {out_valid, out_invalid, out_is_leaf,
                                     out_is_pointer, out_cause[1:0]}, 6'b0);
      check("R11 cause msb cleared", {5'b0, out_cause[2]}, 6'b0);
      out_ready = 1'b1;
   endtask

   initial begin
      t_reset_state();
      t_fixed_cases();
      t_flag_sweep();
      t_ext_field();
      t_mode32();
      t_priority();
      t_handshake();
      t_reset_mid();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule